// File: doc/BRIEF.md
# Serial DAC Host Write Controller

This block is the host side of a three-wire write link to a dual-channel, 16-bit serial converter that takes 24-bit command frames. A client hands it one request through a valid/ready handshake. The request carries a channel select, two load flags, a two-bit operating mode and a 16-bit data word. The block packs these into the converter's command word. It then drives an active-low frame select, a serial clock and a data line. The serial clock is derived from the system clock by a fixed number of cycles per phase.

The controller is a single state machine. Its states are `ST_IDLE`, `ST_SETUP`, `ST_SCLK_HI`, `ST_SCLK_LO`, `ST_TAIL` and `ST_GAP`, with these transitions:
- `ST_IDLE` to `ST_SETUP`: the request is accepted.
- `ST_SETUP` to `ST_SCLK_HI`: the first clock rise.
- `ST_SCLK_HI` to `ST_SCLK_LO`: a falling edge on a bit other than the last.
- `ST_SCLK_LO` to `ST_SCLK_HI`: the next rising edge, where data advances.
- `ST_SCLK_HI` to `ST_TAIL`: the 24th falling edge.
- `ST_TAIL` to `ST_GAP`: frame select rises.
- `ST_GAP` to `ST_IDLE`: the request ends and done pulses.
- `ST_GAP` to `ST_SETUP`: the second frame of a dual request starts.

Each phase lasts a whole number of system cycles, and the phase lengths are checked at elaboration against the converter's minimum timing. A dual request writes both channels and updates them at the same moment. It carries two data words and becomes two frames: the first fills buffer A without loading, and the second fills buffer B and loads both channels.

Top module: `sdac_frame_master`

## Requirements
- R1: While reset is held, and after it is released with no request, `dac_sel_n` is 1, `dac_sclk` is 0, `dac_din` is 0, `req_ready` is 1, `busy` is 0 and `done` is 0.
- R2: Every frame keeps `dac_sel_n` low from its start until after exactly 24 falling edges of `dac_sclk`. The frame carries its command word most significant bit first, and `dac_sclk` is high only while `dac_sel_n` is low.
- R3: `dac_din` changes only together with a rising edge of `dac_sclk`, or when `dac_sel_n` changes. It is constant through each high phase and across each falling edge.
- R4: After `dac_sel_n` falls, `dac_sclk` stays low for `HALF_CYC` cycles. Each later high phase and low phase inside a frame lasts exactly `HALF_CYC` system cycles.
- R5: The command word is laid out as follows, counting bit 23 as the most significant:
  - bits 23 and 22: always 0
  - bit 21: load channel B
  - bit 20: load channel A
  - bit 19: always 0
  - bit 18: buffer select, 0 for A and 1 for B
  - bits 17 and 16: mode
  - bits 15 to 0: data

  For a single request these fields come from `req_load_b`, `req_load_a`, `req_chan`, `req_mode` and `req_data`.
- R6: After the 24th falling edge, `dac_sel_n` stays low for `TAIL_CYC` cycles. It then stays high for `GAP_CYC` cycles before any new frame. This puts at least `TAIL_CYC+GAP_CYC` cycles between a last falling edge and the next fall of `dac_sel_n`.
- R7: `req_ready` is high exactly when the controller is idle. A request is taken at a clock edge where `req_valid` and `req_ready` are both high, and `dac_sel_n` is low in the very next cycle. `busy` is high from that cycle until the last gap cycle.
- R8: `done` is a one-cycle pulse in the first cycle after the final gap of a request, when `busy` is low and `req_ready` is high again. There is exactly one pulse per accepted request.
- R9: When `req_dual` is 1, one request yields two back-to-back frames with no done pulse between them. The first has buffer select 0, both load bits 0 and `req_data`. The second has buffer select 1, both load bits 1 and `req_data_b`. Both use `req_mode`, and `req_chan`, `req_load_a` and `req_load_b` have no effect.
- R10: While `busy` is high, `req_valid` and the request fields are ignored: no extra frame starts, and the frame in flight keeps the values captured at acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_dual | input | 1 | Write both channels and update them together |
| req_chan | input | 1 | Buffer select for a single request (0 = A, 1 = B) |
| req_load_a | input | 1 | Load channel A on this frame |
| req_load_b | input | 1 | Load channel B on this frame |
| req_mode | input | 2 | Operating mode field |
| req_data | input | 16 | Data word (channel A word in dual mode) |
| req_data_b | input | 16 | Channel B word in dual mode |
| busy | output | 1 | Request in progress, gaps included |
| done | output | 1 | One-cycle end-of-request pulse |
| dac_sel_n | output | 1 | Frame select to the converter, active low |
| dac_sclk | output | 1 | Serial clock, idle low |
| dac_din | output | 1 | Serial data, valid around falling clock edges |

## Verification
The assertions take for granted that reset is applied before the first request and that the parameters passed the elaboration timing check. They assume nothing about the request inputs, which may toggle in any cycle, because fields are captured only at the accepting edge. The stimulus therefore holds `req_valid` high and alters every field while a request is in flight, and it also keeps `req_valid` high into the done cycle to exercise back-to-back acceptance. Dual requests are given conflicting single-mode fields to confirm that they are overridden.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

    localparam int FRAME_BITS = 24;
    localparam int DATA_W     = 16;
    localparam int MODE_W     = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SCLK_HI,
        ST_SCLK_LO,
        ST_TAIL,
        ST_GAP
    } sdac_state_e;

    typedef struct packed {
        logic              load_b;
        logic              load_a;
        logic              buf_sel;
        logic [MODE_W-1:0] mode;
        logic [DATA_W-1:0] data;
    } sdac_cmd_t;

endpackage

// File: rtl/sdac_word_pack.sv
module sdac_word_pack
    import sdac_pkg::*;
(
    input  sdac_cmd_t              cmd,
    output logic [FRAME_BITS-1:0]  word
);

    // Field positions are fixed by the receiving converter.
    always_comb begin
        word = '0;
        word[21]                   = cmd.load_b;
        word[20]                   = cmd.load_a;
        word[18]                   = cmd.buf_sel;
        word[DATA_W+MODE_W-1:DATA_W] = cmd.mode;
        word[DATA_W-1:0]           = cmd.data;
    end

endmodule

// File: rtl/sdac_phase_timer.sv
module sdac_phase_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] count;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (count != '0) begin
            count <= count - 1'b1;
        end
    end

    assign expired = (count == '0);

endmodule

// File: rtl/sdac_bit_shifter.sv
module sdac_bit_shifter #(
    parameter int WIDTH = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_word,
    input  logic             shift,
    output logic             msb,
    output logic             last
);

    localparam int LEFT_W = $clog2(WIDTH);

    logic [WIDTH-1:0]  sreg;
    logic [LEFT_W-1:0] left;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg <= '0;
            left <= '0;
        end else if (load) begin
            sreg <= load_word;
            left <= LEFT_W'(WIDTH - 1);
        end else if (shift) begin
            sreg <= {sreg[WIDTH-2:0], 1'b0};
            left <= left - 1'b1;
        end
    end

    assign msb  = sreg[WIDTH-1];
    assign last = (left == '0);

endmodule

// File: rtl/sdac_frame_master.sv
module sdac_frame_master
    import sdac_pkg::*;
#(
    parameter int SYS_CLK_NS         = 4,
    parameter int HALF_CYC           = 5,
    parameter int TAIL_CYC           = 2,
    parameter int GAP_CYC            = 24,
    parameter int MIN_PERIOD_NS      = 33,
    parameter int MIN_PHASE_NS       = 13,
    parameter int MIN_SETUP_NS       = 5,
    parameter int MIN_HOLD_NS        = 5,
    parameter int MIN_SEL_HIGH_NS    = 33,
    parameter int MIN_FALL_TO_SEL_NS = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_dual,
    input  logic              req_chan,
    input  logic              req_load_a,
    input  logic              req_load_b,
    input  logic [MODE_W-1:0] req_mode,
    input  logic [DATA_W-1:0] req_data,
    input  logic [DATA_W-1:0] req_data_b,
    output logic              busy,
    output logic              done,
    output logic              dac_sel_n,
    output logic              dac_sclk,
    output logic              dac_din
);

    localparam int MAX_DUR = (HALF_CYC > TAIL_CYC)
                           ? ((HALF_CYC > GAP_CYC) ? HALF_CYC : GAP_CYC)
                           : ((TAIL_CYC > GAP_CYC) ? TAIL_CYC : GAP_CYC);
    localparam int PHASE_W = $clog2(MAX_DUR + 1);
    localparam logic [PHASE_W-1:0] HALF_LD = PHASE_W'(HALF_CYC - 1);
    localparam logic [PHASE_W-1:0] TAIL_LD = PHASE_W'(TAIL_CYC - 1);
    localparam logic [PHASE_W-1:0] GAP_LD  = PHASE_W'(GAP_CYC - 1);
    localparam int RUN_W = 16;

    // ---------------------------------------------------------------
    // Elaboration-time timing checks against the converter minimums
    // ---------------------------------------------------------------
    if (HALF_CYC * SYS_CLK_NS < MIN_PHASE_NS) begin : g_bad_phase
        $error("serial clock phase shorter than minimum high/low time");
    end
    if (2 * HALF_CYC * SYS_CLK_NS < MIN_PERIOD_NS) begin : g_bad_period
        $error("serial clock period shorter than minimum");
    end
    if (HALF_CYC * SYS_CLK_NS < MIN_SETUP_NS || HALF_CYC * SYS_CLK_NS < MIN_HOLD_NS) begin : g_bad_data
        $error("data setup or hold around the falling edge too short");
    end
    if (TAIL_CYC < 1 || TAIL_CYC * SYS_CLK_NS < MIN_HOLD_NS) begin : g_bad_tail
        $error("tail after last falling edge too short");
    end
    if (GAP_CYC * SYS_CLK_NS < MIN_SEL_HIGH_NS) begin : g_bad_gap
        $error("frame select high time too short");
    end
    if ((TAIL_CYC + GAP_CYC) * SYS_CLK_NS < MIN_FALL_TO_SEL_NS) begin : g_bad_turn
        $error("last falling edge to next frame start too short");
    end

    // ---------------------------------------------------------------
    // State and request capture
    // ---------------------------------------------------------------
    sdac_state_e state, state_d;

    logic                  phase_load;
    logic [PHASE_W-1:0]    phase_val;
    logic                  phase_done;
    logic                  sh_load;
    logic                  sh_shift;
    logic [FRAME_BITS-1:0] sh_word;
    logic                  sh_msb;
    logic                  sh_last;
    logic                  finish;
    logic                  take_second;
    logic                  second_pend;

    sdac_cmd_t             first_cmd;
    sdac_cmd_t             second_cmd;
    sdac_cmd_t             second_cmd_d;
    logic [FRAME_BITS-1:0] first_word;
    logic [FRAME_BITS-1:0] second_word;

    logic sel_n_q;
    logic sclk_q;
    logic busy_q;
    logic done_q;

    // First frame: either the single request or buffer A of a dual one.
    always_comb begin
        if (req_dual) begin
            first_cmd.load_b  = 1'b0;
            first_cmd.load_a  = 1'b0;
            first_cmd.buf_sel = 1'b0;
        end else begin
            first_cmd.load_b  = req_load_b;
            first_cmd.load_a  = req_load_a;
            first_cmd.buf_sel = req_chan;
        end
        first_cmd.mode = req_mode;
        first_cmd.data = req_data;
    end

    // Second frame of a dual request: buffer B, both channels loaded.
    always_comb begin
        second_cmd_d.load_b  = 1'b1;
        second_cmd_d.load_a  = 1'b1;
        second_cmd_d.buf_sel = 1'b1;
        second_cmd_d.mode    = req_mode;
        second_cmd_d.data    = req_data_b;
    end

    sdac_word_pack i_pack_first (
        .cmd  (first_cmd),
        .word (first_word)
    );

    sdac_word_pack i_pack_second (
        .cmd  (second_cmd),
        .word (second_word)
    );

    sdac_phase_timer #(
        .CNT_W (PHASE_W)
    ) i_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (phase_load),
        .load_val (phase_val),
        .expired  (phase_done)
    );

    sdac_bit_shifter #(
        .WIDTH (FRAME_BITS)
    ) i_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (sh_load),
        .load_word (sh_word),
        .shift     (sh_shift),
        .msb       (sh_msb),
        .last      (sh_last)
    );

    assign req_ready = (state == ST_IDLE);

    // Next-state and datapath control
    always_comb begin
        state_d     = state;
        phase_load  = 1'b0;
        phase_val   = HALF_LD;
        sh_load     = 1'b0;
        sh_shift    = 1'b0;
        sh_word     = first_word;
        finish      = 1'b0;
        take_second = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d    = ST_SETUP;
                    sh_load    = 1'b1;
                    phase_load = 1'b1;
                end
            end
            ST_SETUP: begin
                if (phase_done) begin
                    state_d    = ST_SCLK_HI;
                    phase_load = 1'b1;
                end
            end
            ST_SCLK_HI: begin
                if (phase_done) begin
                    phase_load = 1'b1;
                    if (sh_last) begin
                        state_d   = ST_TAIL;
                        phase_val = TAIL_LD;
                    end else begin
                        state_d = ST_SCLK_LO;
                    end
                end
            end
            ST_SCLK_LO: begin
                if (phase_done) begin
                    state_d    = ST_SCLK_HI;
                    phase_load = 1'b1;
                    sh_shift   = 1'b1;
                end
            end
            ST_TAIL: begin
                if (phase_done) begin
                    state_d    = ST_GAP;
                    phase_load = 1'b1;
                    phase_val  = GAP_LD;
                end
            end
            ST_GAP: begin
                if (phase_done) begin
                    if (second_pend) begin
                        state_d     = ST_SETUP;
                        phase_load  = 1'b1;
                        sh_load     = 1'b1;
                        sh_word     = second_word;
                        take_second = 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                        finish  = 1'b1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_d;
        end
    end

    // Request capture for the second frame of a dual request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            second_pend <= 1'b0;
            second_cmd  <= '0;
        end else if (state == ST_IDLE && req_valid) begin
            second_pend <= req_dual;
            second_cmd  <= second_cmd_d;
        end else if (take_second) begin
            second_pend <= 1'b0;
        end
    end

    // Registered outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_n_q <= 1'b1;
            sclk_q  <= 1'b0;
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            sel_n_q <= !(state_d == ST_SETUP || state_d == ST_SCLK_HI ||
                         state_d == ST_SCLK_LO || state_d == ST_TAIL);
            sclk_q  <= (state_d == ST_SCLK_HI);
            busy_q  <= (state_d != ST_IDLE);
            done_q  <= finish;
        end
    end

    assign dac_sel_n = sel_n_q;
    assign dac_sclk  = sclk_q;
    assign dac_din   = sel_n_q ? 1'b0 : sh_msb;
    assign busy      = busy_q;
    assign done      = done_q;

    // ---------------------------------------------------------------
    // Line monitors feeding the assertions
    // ---------------------------------------------------------------
    logic             sclk_prev;
    logic [4:0]       fall_cnt;
    logic [RUN_W-1:0] hi_run;
    logic [RUN_W-1:0] lo_run;
    logic [RUN_W-1:0] sel_hi_run;
    logic [RUN_W-1:0] since_fall;
    logic             fall_seen;

    assign fall_seen = sclk_prev && !sclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev  <= 1'b0;
            fall_cnt   <= '0;
            hi_run     <= '0;
            lo_run     <= '1;
            sel_hi_run <= '1;
            since_fall <= '1;
        end else begin
            sclk_prev  <= sclk_q;
            fall_cnt   <= sel_n_q ? 5'd0 : (fall_cnt + 5'(fall_seen));
            hi_run     <= !sclk_q ? '0 : ((hi_run == '1) ? hi_run : hi_run + 1'b1);
            lo_run     <= sclk_q ? '0 : ((lo_run == '1) ? lo_run : lo_run + 1'b1);
            sel_hi_run <= !sel_n_q ? '0 : ((sel_hi_run == '1) ? sel_hi_run : sel_hi_run + 1'b1);
            since_fall <= fall_seen ? RUN_W'(1)
                        : ((since_fall == '1) ? since_fall : since_fall + 1'b1);
        end
    end

    p_sclk_inside_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dac_sclk |-> !dac_sel_n);

    p_frame_has_24_falls_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_sel_n) |-> (fall_cnt == 5'(FRAME_BITS)));

    p_data_steady_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_sclk && $past(dac_sclk)) |-> $stable(dac_din));

    p_data_hold_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_sclk) |-> $stable(dac_din));

    p_high_phase_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_sclk) |-> (hi_run >= RUN_W'(HALF_CYC)));

    p_low_phase_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_sclk) |-> (lo_run >= RUN_W'(HALF_CYC)));

    p_sel_high_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_sel_n) |-> (sel_hi_run >= RUN_W'(GAP_CYC)));

    p_fall_to_next_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_sel_n) |-> (since_fall >= RUN_W'(TAIL_CYC + GAP_CYC)));

    p_done_single_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (req_ready && !busy && dac_sel_n));

endmodule

// File: tb/test_sdac_frame_master.sv
module test_sdac_frame_master;

    localparam int HALF = 5;
    localparam int TAIL = 2;
    localparam int GAP  = 24;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic        req_dual;
    logic        req_chan;
    logic        req_load_a;
    logic        req_load_b;
    logic [1:0]  req_mode;
    logic [15:0] req_data;
    logic [15:0] req_data_b;
    logic        busy;
    logic        done;
    logic        dac_sel_n;
    logic        dac_sclk;
    logic        dac_din;

    always #2 clk = ~clk;

    sdac_frame_master #(
        .HALF_CYC (HALF),
        .TAIL_CYC (TAIL),
        .GAP_CYC  (GAP)
    ) i_sdac_frame_master (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_dual   (req_dual),
        .req_chan   (req_chan),
        .req_load_a (req_load_a),
        .req_load_b (req_load_b),
        .req_mode   (req_mode),
        .req_data   (req_data),
        .req_data_b (req_data_b),
        .busy       (busy),
        .done       (done),
        .dac_sel_n  (dac_sel_n),
        .dac_sclk   (dac_sclk),
        .dac_din    (dac_din)
    );

    // Expected line state per cycle: {sel_n, sclk, din, busy, done}
    typedef logic [4:0] exp_t;

    exp_t        exp_q[$];
    logic [23:0] word_q[$];
    int          checks    = 0;
    int          errors    = 0;
    int          cyc       = 0;
    int          accepted  = 0;
    int          done_seen = 0;
    logic        exp_ready = 1'b1;
    logic        took      = 1'b0;
    string       din_tag   = "R5";

    // Receiver-side monitor state
    logic        p_sel_n    = 1'b1;
    logic        p_sclk     = 1'b0;
    logic        p_din      = 1'b0;
    logic [23:0] rx_word    = '0;
    int          rx_bits    = 0;
    int          sel_hi_cnt = 1000;
    int          since_fall = 1000;

    function automatic logic [23:0] mk_word(logic lb, logic la, logic ch,
                                            logic [1:0] md, logic [15:0] d);
        return {2'b00, lb, la, 1'b0, ch, md, d};
    endfunction

    function automatic void push_frame(logic [23:0] w);
        word_q.push_back(w);
        for (int i = 0; i < HALF; i++) exp_q.push_back({1'b0, 1'b0, w[23], 1'b1, 1'b0});
        for (int k = 1; k <= 24; k++) begin
            for (int i = 0; i < HALF; i++) exp_q.push_back({1'b0, 1'b1, w[24-k], 1'b1, 1'b0});
            if (k < 24) begin
                for (int i = 0; i < HALF; i++) exp_q.push_back({1'b0, 1'b0, w[24-k], 1'b1, 1'b0});
            end
        end
        for (int i = 0; i < TAIL; i++) exp_q.push_back({1'b0, 1'b0, w[0], 1'b1, 1'b0});
        for (int i = 0; i < GAP; i++)  exp_q.push_back({1'b1, 1'b0, 1'b0, 1'b1, 1'b0});
    endfunction

    function automatic void push_request();
        if (req_dual) begin
            push_frame(mk_word(1'b0, 1'b0, 1'b0, req_mode, req_data));
            push_frame(mk_word(1'b1, 1'b1, 1'b1, req_mode, req_data_b));
        end else begin
            push_frame(mk_word(req_load_b, req_load_a, req_chan, req_mode, req_data));
        end
        exp_q.push_back({1'b1, 1'b0, 1'b0, 1'b0, 1'b1});
        accepted++;
    endfunction

    task automatic check_val(string tag, string what, int got, int expv);
        checks++;
        if (got != expv) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, got, expv, cyc);
        end
    endtask

    task automatic check_ge(string tag, string what, int got, int minv);
        checks++;
        if (got < minv) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected at least %0d (cycle %0d)", tag, what, got, minv, cyc);
        end
    endtask

    // One clock: model acceptance, advance, compare at the falling edge.
    task automatic tick();
        exp_t e;
        took = 1'b0;
        if (req_valid && exp_ready) begin
            push_request();
            took = 1'b1;
        end
        @(negedge clk);
        cyc++;
        e = (exp_q.size() > 0) ? exp_q.pop_front() : 5'b10000;
        check_val("R2", "sel_n", int'(dac_sel_n), int'(e[4]));
        check_val("R4", "sclk", int'(dac_sclk), int'(e[3]));
        check_val(din_tag, "din", int'(dac_din), int'(e[2]));
        check_val("R7", "busy", int'(busy), int'(e[1]));
        check_val("R7", "ready", int'(req_ready), int'(!e[1]));
        check_val("R8", "done", int'(done), int'(e[0]));
        exp_ready = !e[1];
        if (done) done_seen++;

        // R3: data moves only with a rising clock edge or a select change
        if (!p_sel_n && !dac_sel_n && !dac_sclk) check_val("R3", "din held while clock low", int'(dac_din), int'(p_din));
        if (p_sclk && dac_sclk) check_val("R3", "din held while clock high", int'(dac_din), int'(p_din));

        since_fall++;
        if (p_sclk && !dac_sclk) begin
            rx_word = {rx_word[22:0], p_din};
            rx_bits++;
            since_fall = 0;
        end
        if (p_sel_n && !dac_sel_n) begin
            check_ge("R6", "select high cycles before frame", sel_hi_cnt, GAP);
            check_ge("R6", "cycles from last fall to frame", since_fall, TAIL + GAP);
            rx_bits    = 0;
            sel_hi_cnt = 0;
        end
        if (!p_sel_n && dac_sel_n) begin
            check_val("R2", "falling edges in frame", rx_bits, 24);
            check_val("R6", "tail cycles", since_fall, TAIL);
            if (word_q.size() > 0) begin
                logic [23:0] w;
                w = word_q.pop_front();
                checks++;
                if (rx_word !== w) begin
                    errors++;
                    $display("FAIL %s frame word: actual %h expected %h (cycle %0d)", din_tag, rx_word, w, cyc);
                end
            end else begin
                check_val("R10", "unexpected frame", 1, 0);
            end
        end
        if (dac_sel_n) sel_hi_cnt++;
        p_sel_n = dac_sel_n;
        p_sclk  = dac_sclk;
        p_din   = dac_din;
    endtask

    task automatic send(logic dual, logic ch, logic la, logic lb,
                        logic [1:0] md, logic [15:0] da, logic [15:0] db);
        req_dual   = dual;
        req_chan   = ch;
        req_load_a = la;
        req_load_b = lb;
        req_mode   = md;
        req_data   = da;
        req_data_b = db;
        req_valid  = 1'b1;
        tick();
        while (!took) tick();
        // R7: select low in the cycle right after acceptance
        check_val("R7", "sel_n after accept", int'(dac_sel_n), 0);
        check_val("R7", "busy after accept", int'(busy), 1);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() > 0) tick();
        for (int i = 0; i < 4; i++) tick();
    endtask

    initial begin
        rst_n      = 1'b0;
        req_valid  = 1'b0;
        req_dual   = 1'b0;
        req_chan   = 1'b0;
        req_load_a = 1'b0;
        req_load_b = 1'b0;
        req_mode   = 2'b00;
        req_data   = '0;
        req_data_b = '0;
        for (int i = 0; i < 3; i++) @(negedge clk);
        // R1: values while reset is held
        check_val("R1", "sel_n in reset", int'(dac_sel_n), 1);
        check_val("R1", "sclk in reset", int'(dac_sclk), 0);
        check_val("R1", "din in reset", int'(dac_din), 0);
        check_val("R1", "ready in reset", int'(req_ready), 1);
        check_val("R1", "busy in reset", int'(busy), 0);
        check_val("R1", "done in reset", int'(done), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 5; i++) tick();
        check_val("R1", "idle after reset sel_n", int'(dac_sel_n), 1);

        // R5: single write to buffer A with load A, normal mode
        din_tag = "R5";
        send(1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 16'hA5C3, 16'h0000);
        drain();

        // R5: buffer B, load B only, mode 11, data at the low end
        send(1'b0, 1'b1, 1'b0, 1'b1, 2'b11, 16'h0001, 16'hFFFF);
        drain();

        // R10: load both, then keep valid high with other fields while busy
        din_tag = "R10";
        send(1'b0, 1'b1, 1'b1, 1'b1, 2'b01, 16'hFFFF, 16'h0000);
        req_valid  = 1'b1;
        req_dual   = 1'b1;
        req_chan   = 1'b0;
        req_mode   = 2'b10;
        req_data   = 16'h1357;
        req_data_b = 16'h2468;
        for (int i = 0; i < 150; i++) tick();
        req_valid = 1'b0;
        drain();

        // R9: dual request with conflicting single-mode fields
        din_tag = "R9";
        send(1'b1, 1'b1, 1'b1, 1'b0, 2'b10, 16'h1234, 16'hFEDC);
        drain();

        // R8: back-to-back requests, second taken in the done cycle
        din_tag = "R8";
        send(1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 16'h8000, 16'h0000);
        send(1'b0, 1'b1, 1'b0, 1'b1, 2'b00, 16'h7FFF, 16'h0000);
        check_val("R8", "done pulses before second frame", done_seen, accepted - 1);
        drain();

        check_val("R8", "done pulses per request", done_seen, accepted);
        check_val("R2", "frames left unchecked", word_q.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 150000);
        checks++;
        errors++;
        $display("FAIL R7 watchdog: actual still running expected finished (cycle %0d)", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule